// File: doc/BRIEF.md
# Directional Latch-or-Register Bus Transceiver Slice

This block carries one direction of a bidirectional bus transceiver. A source-side word enters on `a_i` and leaves on the destination side as `b_o`, paired with a per-bit drive-enable `b_drv_o` and a resolved view `b_pin_o` in which undriven bits read as high impedance. Each bit has one storage element. While its latch enable is high, the element is transparent. While the latch enable is low, the element behaves as a register that loads on a rising edge of the capture clock. The output enable is active low and decides whether the destination bits are driven at all.

The word is split into `NGRP` equal groups. By default there are two halves, and each half has its own latch enable, capture clock and output enable. When `join_i` is high, every group follows the controls of group 0, so the word acts as one full-width transceiver. The opposite direction uses a second instance with its own controls.

The capture clock and latch enable are sampled on the system clock `clk`. A capture-clock rising edge is seen at the first `clk` edge at which the capture input is high after it was low at the previous `clk` edge. The storage powers up unknown. A synchronous active-high `rst` clears it to zero.

Top module: `xfer_slice`

## Requirements
- R1: At a `clk` edge with `rst` high, every storage bit becomes 0. Rst takes priority over every other control in that cycle, including a capture edge.
- R2: While a group's effective latch enable is 1, that group's bits of `b_o` equal the same bits of `a_i` in the same cycle (transparent mode).
- R3: While a group's latch enable is 0 and its capture input shows no rising edge, the group's `b_o` bits keep their stored value, whatever `a_i` does.
- R4: At a `clk` edge where a group's latch enable is 0, its capture input is 1, and that capture input was 0 at the previous edge, the group stores `a_i`. The new value shows on `b_o` after that edge.
- R5: When the latch enable drops to 0, the group keeps the `a_i` value it sampled at the last `clk` edge with latch enable 1. No capture edge is needed for this.
- R6: If a falling latch enable and a rising capture input are sampled at the same `clk` edge, the group stores the `a_i` present at that edge.
- R7: A group's `b_drv_o` bits are 1 when its output enable is 0 and 0 when its output enable is 1. Each `b_pin_o` bit equals its `b_o` bit when driven and is `z` when not driven.
- R8: With `join_i` = 0, group g owns bits [g*GW +: GW], with group 0 in the lowest bits, and is governed only by control bit g of `le_i`, `cap_i` and `oe_n_i`.
- R9: With `join_i` = 1, every group uses control bit 0, and control bits above 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the capture inputs and latch enables |
| rst | input | 1 | Synchronous active-high clear of storage |
| join_i | input | 1 | 1: all groups use the group 0 controls |
| le_i | input | NGRP | Latch enable per group (1 = transparent) |
| cap_i | input | NGRP | Capture clock per group; a rising edge loads storage while latched |
| oe_n_i | input | NGRP | Active-low output enable per group |
| a_i | input | WIDTH | Source-side data bus |
| b_o | output | WIDTH | Destination-side data value |
| b_drv_o | output | WIDTH | Per-bit drive enable |
| b_pin_o | output | WIDTH | Resolved destination bus, `z` where not driven |

## Verification
Two functions can meet at one `clk` edge: the latch enable closing and a capture-clock rising edge. The bench forces this by dropping `le_i` and raising `cap_i` in the same stimulus step, with a new `a_i`. A correct result holds the new word, not the word sampled while transparent, and this is visible on `b_o` in the following cycle. A reset coinciding with a capture edge is also provoked, and the bench expects zero. Every step is compared against a behavioural per-group model that tracks the stored word and the previous capture level.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    // Per-group control set of one transceiver direction
    typedef struct packed {
        logic le;    // 1: transparent
        logic cap;   // capture clock level
        logic oe_n;  // active-low drive enable
    } xfer_ctl_t;

    // Rising edge of a sampled level
    function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
        return now_lvl & ~prev_lvl;
    endfunction

endpackage

// File: rtl/xfer_route.sv
module xfer_route
    import xfer_pkg::*;
#(
    parameter int NGRP = 2
) (
    input  logic                  join_i,
    input  xfer_ctl_t [NGRP-1:0]  ctl_i,
    output xfer_ctl_t [NGRP-1:0]  ctl_o
);

    // In joined mode every group follows group 0
    for (genvar g = 0; g < NGRP; g++) begin : g_route
        if (g == 0) begin : g_base
            assign ctl_o[g] = ctl_i[0];
        end else begin : g_upper
            assign ctl_o[g] = join_i ? ctl_i[0] : ctl_i[g];
        end
    end

endmodule

// File: rtl/xfer_cell.sv
module xfer_cell
    import xfer_pkg::*;
#(
    parameter int GW = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  xfer_ctl_t      ctl,
    input  logic [GW-1:0]  din,
    output logic [GW-1:0]  q,
    output logic [GW-1:0]  drv
);

    logic          cap_q;
    logic          cap_rise;
    logic [GW-1:0] store_q;

    // Previous capture level, kept even during reset so no false edge follows it
    always_ff @(posedge clk) begin
        cap_q <= ctl.cap;
    end

    assign cap_rise = rise_of(ctl.cap, cap_q);

    // Storage: tracks while transparent, loads on a capture edge while latched
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (ctl.le) begin
            store_q <= din;
        end else if (cap_rise) begin
            store_q <= din;
        end
    end

    assign q   = ctl.le ? din : store_q;
    assign drv = {GW{~ctl.oe_n}};

    // R1: reset clears storage, regardless of capture activity
    a_r1_clear: assert property (@(posedge clk) rst |=> (store_q == '0));

    // R5: while transparent, storage holds the word seen at the edge
    a_r5_track: assert property (@(posedge clk) disable iff (rst)
        ctl.le |=> (store_q == $past(din)));

    // R4: latched capture edge loads the input word
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        (!ctl.le && ctl.cap && !cap_q) |=> (store_q == $past(din)));

    // R3: latched with no edge keeps storage
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.le && !(ctl.cap && !cap_q)) |=> $stable(store_q));

endmodule

// File: rtl/xfer_slice.sv
module xfer_slice
    import xfer_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int NGRP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             join_i,
    input  logic [NGRP-1:0]  le_i,
    input  logic [NGRP-1:0]  cap_i,
    input  logic [NGRP-1:0]  oe_n_i,
    input  logic [WIDTH-1:0] a_i,
    output logic [WIDTH-1:0] b_o,
    output logic [WIDTH-1:0] b_drv_o,
    output logic [WIDTH-1:0] b_pin_o
);

    localparam int GW = WIDTH / NGRP;

    xfer_ctl_t [NGRP-1:0] raw_ctl;
    xfer_ctl_t [NGRP-1:0] eff_ctl;

    for (genvar g = 0; g < NGRP; g++) begin : g_pack
        assign raw_ctl[g].le   = le_i[g];
        assign raw_ctl[g].cap  = cap_i[g];
        assign raw_ctl[g].oe_n = oe_n_i[g];
    end

    xfer_route #(.NGRP(NGRP)) u_route (
        .join_i (join_i),
        .ctl_i  (raw_ctl),
        .ctl_o  (eff_ctl)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_cell
        xfer_cell #(.GW(GW)) u_cell (
            .clk (clk),
            .rst (rst),
            .ctl (eff_ctl[g]),
            .din (a_i[g*GW +: GW]),
            .q   (b_o[g*GW +: GW]),
            .drv (b_drv_o[g*GW +: GW])
        );
    end

    // High impedance appears only here, at the bus edge
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign b_pin_o[i] = b_drv_o[i] ? b_o[i] : 1'bz;
    end

endmodule

// File: tb/xfer_slice_test.sv
module xfer_slice_test;

    localparam int PERIOD = 10;
    localparam int W  = 18;
    localparam int G  = 2;
    localparam int GW = W / G;

    logic         clk = 1'b0;
    logic         rst;
    logic         join_i;
    logic [G-1:0] le, cap, oen;
    logic [W-1:0] a;
    logic [W-1:0] q, drv, pin;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [W-1:0] m_store;
    logic [G-1:0] m_prevcap;

    always #(PERIOD/2) clk = ~clk;

    xfer_slice #(.WIDTH(W), .NGRP(G)) uut (
        .clk     (clk),
        .rst     (rst),
        .join_i  (join_i),
        .le_i    (le),
        .cap_i   (cap),
        .oe_n_i  (oen),
        .a_i     (a),
        .b_o     (q),
        .b_drv_o (drv),
        .b_pin_o (pin)
    );

    task automatic step(input logic r, input logic j, input logic [G-1:0] l,
                        input logic [G-1:0] c, input logic [G-1:0] o,
                        input logic [W-1:0] d, input string tag);
        logic [W-1:0] eq, ed, ep;
        @(negedge clk);
        rst = r; join_i = j; le = l; cap = c; oen = o; a = d;
        #1;
        if (!r && tag != "") begin
            for (int g = 0; g < G; g++) begin
                int s = j ? 0 : g;
                for (int b = 0; b < GW; b++) begin
                    int i = g*GW + b;
                    eq[i] = l[s] ? d[i] : m_store[i];
                    ed[i] = ~o[s];
                    ep[i] = ed[i] ? eq[i] : 1'bz;
                end
            end
            total++;
            if (q !== eq || drv !== ed || pin !== ep) begin
                bad++;
                $display("FAIL %s: q=%h exp %h drv=%h exp %h pin=%b exp %b",
                         tag, q, eq, drv, ed, pin, ep);
            end
        end
        @(posedge clk);
        for (int g = 0; g < G; g++) begin
            int s = j ? 0 : g;
            for (int b = 0; b < GW; b++) begin
                int i = g*GW + b;
                if (r)                             m_store[i] = 1'b0;
                else if (l[s])                     m_store[i] = d[i];
                else if (c[s] && !m_prevcap[g])    m_store[i] = d[i];
            end
            m_prevcap[g] = c[s];
        end
    endtask

    initial begin
        #(PERIOD*200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1: watchdog expired, actual hung expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(1, 0, 2'b00, 2'b00, 2'b00, '0, "");
        step(1, 0, 2'b00, 2'b00, 2'b00, '0, "");
        // R1: reset state with latch closed
        step(0, 0, 2'b00, 2'b00, 2'b00, 18'h3ffff, "R1");
        // R2: transparent, several patterns
        step(0, 0, 2'b11, 2'b00, 2'b00, 18'h12345, "R2");
        step(0, 0, 2'b11, 2'b00, 2'b00, 18'h2aaaa, "R2");
        step(0, 0, 2'b11, 2'b00, 2'b00, 18'h15555, "R2");
        // R5: closing the latch keeps the last sampled word
        step(0, 0, 2'b00, 2'b00, 2'b00, 18'h3c3c3, "R5");
        step(0, 0, 2'b00, 2'b00, 2'b00, 18'h00000, "R5");
        // R4: capture edge while latched
        step(0, 0, 2'b00, 2'b11, 2'b00, 18'h0a0a0, "R4");
        step(0, 0, 2'b00, 2'b11, 2'b00, 18'h11111, "R4");
        // R3: steady capture levels hold
        step(0, 0, 2'b00, 2'b00, 2'b00, 18'h22222, "R3");
        step(0, 0, 2'b00, 2'b00, 2'b00, 18'h33333, "R3");
        // R6: latch closes at the same edge as a capture edge
        step(0, 0, 2'b11, 2'b00, 2'b00, 18'h01234, "R2");
        step(0, 0, 2'b00, 2'b11, 2'b00, 18'h04321, "R6");
        step(0, 0, 2'b00, 2'b11, 2'b00, 18'h00000, "R6");
        // R7: output enables
        step(0, 0, 2'b00, 2'b00, 2'b11, 18'h3ffff, "R7");
        step(0, 0, 2'b00, 2'b00, 2'b01, 18'h3ffff, "R7");
        step(0, 0, 2'b00, 2'b00, 2'b10, 18'h3ffff, "R7");
        // R8: independent halves
        step(0, 0, 2'b01, 2'b00, 2'b00, 18'h2f0f1, "R8");
        step(0, 0, 2'b10, 2'b00, 2'b00, 18'h1e1e2, "R8");
        step(0, 0, 2'b00, 2'b10, 2'b00, 18'h37777, "R8");
        step(0, 0, 2'b00, 2'b10, 2'b00, 18'h00001, "R8");
        // R9: joined word, upper controls ignored
        step(0, 1, 2'b00, 2'b00, 2'b10, 18'h00000, "R9");
        step(0, 1, 2'b10, 2'b10, 2'b10, 18'h2bcde, "R9");
        step(0, 1, 2'b10, 2'b10, 2'b10, 18'h0abcd, "R9");
        step(0, 1, 2'b00, 2'b01, 2'b10, 18'h13579, "R9");
        step(0, 1, 2'b00, 2'b01, 2'b00, 18'h00000, "R9");
        // R1: reset beats a simultaneous capture edge
        step(0, 0, 2'b00, 2'b00, 2'b00, 18'h3ffff, "R3");
        step(1, 0, 2'b00, 2'b11, 2'b00, 18'h3ffff, "");
        step(0, 0, 2'b00, 2'b11, 2'b00, 18'h3ffff, "R1");
        // Mixed stimulus against the model
        for (int n = 0; n < 600; n++) begin
            logic [31:0] rv;
            logic jj;
            rv = $urandom;
            jj = (n % 100) >= 60;
            step(0, jj, rv[1:0], rv[3:2], rv[5:4], 18'($urandom),
                 jj ? "R9" : "R8");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule